// File: doc/BRIEF.md
# Self-Reseeding Ring Cellular Automaton

The block evolves a one-dimensional cellular automaton whose cells sit on a closed ring. Its state goes straight to a bank of LEDs, one LED per cell. A divider counts cycles of the single system clock and raises a one-cycle enable at a fixed interval. Each enable moves the ring forward by one generation. The enable is never used as a clock, so every register in the block shares one clock domain.

A cell looks only at its two ring neighbours in the current generation:
- With neither neighbour alive, the cell keeps its value.
- With exactly one neighbour alive, the cell becomes or stays alive.
- With both neighbours alive, the cell dies.

Two conditions keep the display from freezing:
- **Empty ring.** If every cell is dead, the next enable loads a pattern taken from a free-running linear feedback shift register.
- **Stalemate.** If a computed generation equals the one it came from, the ring is cleared. The following enable then reseeds it.

A synchronous reset loads a fixed seed pattern.

Top module: `ring_automaton`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the state (and `leds`) becomes `SEED` (default 8'b00100100). The shift register becomes a value with only bit N_CELLS-1 set. The divider count returns to zero.
- R2: After reset is released, the first generation step takes effect on the `TICK_DIV`-th rising edge with `rst` low. Later steps follow exactly every `TICK_DIV` edges. No other edge changes the state.
- R3: On a step from a non-empty, non-stalemate state, each new cell value depends on the two neighbours in the old state. With both dead, the cell keeps its value. With exactly one alive, the cell is 1. With both alive, the cell is 0.
- R4: The ring wraps around. Cell i has left neighbour i-1 and right neighbour i+1. Cell 0 uses cell N_CELLS-1 as its left neighbour, and cell N_CELLS-1 uses cell 0 as its right neighbour.
- R5: Every cell of a new generation is computed from the same previous-generation snapshot. No cell sees a neighbour value that was already updated in the same step.
- R6: On a step where the state is all zeros, the state loads the current shift-register value. If that value is zero, the state loads `SEED` instead.
- R7: On a step where the rule would produce a state equal to the current one, the state becomes all zeros.
- R8: The shift register advances once per step, reseed steps included. The new value is the old value shifted left by one, with bit 0 set to old bit N_CELLS-1 XOR old bit N_CELLS-2.
- R9: `leds` always equals the registered state. It holds steady between steps, with no blanking.
- R10: A reset sampled on the same edge as a due step wins over that step. The state becomes `SEED` and the divider restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| leds | output | N_CELLS | Registered cell states, bit i is cell i |

## Verification
The bench drives two copies of the block with different seeds. It targets these corner cases:
- **Fixed-point seed.** One seed is a fixed point of the rule, so the stalemate clear and the reseed from an empty ring happen within two steps. A design that missed the equality test would freeze. A design that loaded the shift register before stepping it would show the wrong pattern.
- **Wrap cells.** Every cycle is compared against a model of the rule, so cells 0 and N_CELLS-1 are checked each step. Neighbour indexing without wraparound would corrupt those cells.
- **Partial updates.** Reading a partly updated ring would corrupt generations even when no reseed occurs.
- **Divider period and reset priority.** An off-by-one divider shifts every step by a cycle. A reset placed on the exact cycle a step is due catches a design that lets the step win.

// File: rtl/ring_ca_pkg.sv
package ring_ca_pkg;

  // Neighbour-count rule: none alive keeps the cell, one alive sets it,
  // two alive clears it.
  function automatic logic cell_next(input logic left, input logic self, input logic right);
    return (left ^ right) | (~left & ~right & self);
  endfunction

endpackage

// File: rtl/ring_tick_div.sv
module ring_tick_div #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // Single-cycle enable taken from the registered count.
  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ring_ca_lfsr.sv
module ring_ca_lfsr #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [N-1:0] val
);
  localparam logic [N-1:0] INIT = N'(1) << (N - 1);

  logic [N-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)      sr_q <= INIT;
    else if (adv) sr_q <= {sr_q[N-2:0], sr_q[N-1] ^ sr_q[N-2]};
  end

  assign val = sr_q;
endmodule

// File: rtl/ring_ca_rule.sv
module ring_ca_rule #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] cur,
  output logic [N-1:0] nxt
);
  import ring_ca_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int unsigned LI = (i == 0)     ? N - 1 : i - 1;
    localparam int unsigned RI = (i == N - 1) ? 0     : i + 1;
    assign nxt[i] = cell_next(cur[LI], cur[i], cur[RI]);
  end
endmodule

// File: rtl/ring_automaton.sv
module ring_automaton #(
  parameter int unsigned       N_CELLS  = 8,
  parameter int unsigned       TICK_DIV = 50_000_000,
  parameter logic [N_CELLS-1:0] SEED    = N_CELLS'(8'b0010_0100)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [N_CELLS-1:0] leds
);
  logic               tick;
  logic [N_CELLS-1:0] state_q;
  logic [N_CELLS-1:0] nxt_gen;
  logic [N_CELLS-1:0] lfsr_val;
  logic [N_CELLS-1:0] reseed_val;

  ring_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ring_ca_lfsr #(.N(N_CELLS)) u_lfsr (
    .clk(clk),
    .rst(rst),
    .adv(tick),
    .val(lfsr_val)
  );

  // Operates on the registered snapshot only.
  ring_ca_rule #(.N(N_CELLS)) u_rule (
    .cur(state_q),
    .nxt(nxt_gen)
  );

  always_comb reseed_val = (lfsr_val == '0) ? SEED : lfsr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (tick) begin
      if (state_q == '0)           state_q <= reseed_val;
      else if (nxt_gen == state_q) state_q <= '0;
      else                         state_q <= nxt_gen;
    end
  end

  assign leds = state_q;
endmodule

// File: rtl/ring_automaton_chk.sv
module ring_automaton_chk #(
  parameter int unsigned       N_CELLS  = 8,
  parameter int unsigned       TICK_DIV = 50_000_000,
  parameter logic [N_CELLS-1:0] SEED    = N_CELLS'(8'b0010_0100)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CELLS-1:0] leds,
  input logic               tick,
  input logic [N_CELLS-1:0] nxt,
  input logic [N_CELLS-1:0] lfsr
);
  localparam int unsigned GW = $clog2(TICK_DIV) + 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(TICK_DIV - 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || tick)            gap_q <= '0;
    else if (gap_q != GAP_LAST) gap_q <= gap_q + 1'b1;
  end

  assert_reset_seed_R1: assert property (@(posedge clk)
    rst |=> leds == SEED);

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap_q == GAP_LAST);

  assert_tick_due_R2: assert property (@(posedge clk) disable iff (rst)
    gap_q == GAP_LAST |-> tick);

  assert_rule_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && leds != '0 && nxt != leds) |=> leds == $past(nxt));

  assert_empty_reseed_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && leds == '0) |=> leds != '0);

  assert_stalemate_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && leds != '0 && nxt == leds) |=> leds == '0);

  assert_lfsr_step_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> lfsr == {$past(lfsr[N_CELLS-2:0]), $past(lfsr[N_CELLS-1] ^ lfsr[N_CELLS-2])});

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(leds));
endmodule

bind ring_automaton ring_automaton_chk #(
  .N_CELLS (N_CELLS),
  .TICK_DIV(TICK_DIV),
  .SEED    (SEED)
) u_chk (
  .clk (clk),
  .rst (rst),
  .leds(leds),
  .tick(tick),
  .nxt (nxt_gen),
  .lfsr(lfsr_val)
);

// File: tb/test_ring_automaton.sv
module test_ring_automaton;
  localparam int unsigned N   = 8;
  localparam int unsigned DIV = 5;
  localparam logic [N-1:0] SEED_A = 8'b0010_0100;
  localparam logic [N-1:0] SEED_B = 8'b1010_1010;   // fixed point of the rule
  localparam logic [N-1:0] LFSR_INIT = 8'b1000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] leds_a, leds_b;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ring_automaton #(.N_CELLS(N), .TICK_DIV(DIV), .SEED(SEED_A)) i_ring_automaton (
    .clk(clk), .rst(rst), .leds(leds_a)
  );
  ring_automaton #(.N_CELLS(N), .TICK_DIV(DIV), .SEED(SEED_B)) i_ring_automaton_alt (
    .clk(clk), .rst(rst), .leds(leds_b)
  );

  // Reference: rule from the requirements with explicit ring indices (R3, R4).
  function automatic logic [N-1:0] ref_gen(input logic [N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int li = (i == 0) ? N - 1 : i - 1;
      int ri = (i == N - 1) ? 0 : i + 1;
      int alive = int'(s[li]) + int'(s[ri]);
      r[i] = (alive == 0) ? s[i] : (alive == 1);
    end
    return r;
  endfunction

  logic [N-1:0] st_a, st_b, lf_a, lf_b;
  int cnt;
  string tag_a, tag_b;

  task automatic model_step(input logic [N-1:0] seed, input bit r, input bit stepping,
                            inout logic [N-1:0] st, inout logic [N-1:0] lf, output string tag);
    logic [N-1:0] n;
    if (r) begin
      st = seed; lf = LFSR_INIT; tag = "R1";
    end else if (stepping) begin
      if (st == '0) begin
        st = (lf == '0) ? seed : lf; tag = "R6 R8";
      end else begin
        n = ref_gen(st);
        if (n == st) begin st = '0; tag = "R7"; end
        else begin st = n; tag = "R3 R4 R5"; end
      end
      lf = {lf[N-2:0], lf[N-1] ^ lf[N-2]};
    end else begin
      tag = "R2 R9";
    end
  endtask

  task automatic check(input string who, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): leds=%b expected=%b", tag, who, act, exp);
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic cycle(input bit r, input string force_tag);
    bit stepping;
    @(posedge clk);
    stepping = !r && (cnt == DIV - 1);
    model_step(SEED_A, r, stepping, st_a, lf_a, tag_a);
    model_step(SEED_B, r, stepping, st_b, lf_b, tag_b);
    if (r) cnt = 0;
    else   cnt = (cnt == DIV - 1) ? 0 : cnt + 1;
    @(negedge clk);
    if (force_tag != "") begin tag_a = force_tag; tag_b = force_tag; end
    check("A", tag_a, leds_a, st_a);
    check("B", tag_b, leds_b, st_b);
  endtask

  initial begin
    st_a = 'x; st_b = 'x; lf_a = 'x; lf_b = 'x; cnt = 0;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b1, "");
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 600; i++) cycle(1'b0, "");
    // Place a reset on the exact edge where a step is due (R10).
    while (cnt != DIV - 1) cycle(1'b0, "");
    rst = 1'b1;
    cycle(1'b1, "R10");
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 600; i++) cycle(1'b0, "");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule